// File: doc/BRIEF.md
# Serial Gain-Code Loader and Gain Decoder

This block is the digital control port of a programmable-gain stage. A controller
frames a serial transfer by pulling an active-low enable low and presents one data
bit per rising clock edge, most significant bit first. The bits enter a seven-bit
shift register, so when a full eight-bit control word is sent, its leading bit is
pushed out on the eighth edge and only the low seven bits remain.

Releasing the enable moves the shift register contents into a holding latch. The
release is seen on one clock edge, the latch loads on the edge after it, and a
one-cycle strobe marks the load. A decoder turns the latched code into a step
index, clamped at 71, and into a signed gain in hundredths of a dB. The gain runs
from -27.43 dB at index 0 up to 26 dB at index 71, rising 0.7526 dB per step. The
lost eighth bit makes the upper half of the word space repeat the lower half.

Top module: `gain_word_loader`

## Requirements
- R1: On each rising clk edge that samples en_n low, the shift register takes sdin into its least significant bit and moves the other bits up. It keeps only the last 7 bits sent, so with an 8-bit word sent MSB first the latched code is word[6:0].
- R2: Rising clk edges that sample en_n high change neither the shift register nor the latch, whatever sdin does.
- R3: The latch loads the shift register contents on the clk edge after the first edge that samples en_n high following a low. step_idx and gain_cdb change only then, and are still at their old values one cycle after the edge that saw the release.
- R4: load_pulse is high for exactly one clock cycle, the cycle in which the newly latched values first appear. It is low at every other time.
- R5: Bit 7 of an 8-bit word has no effect: words w and w+128 give the same step_idx and gain_cdb.
- R6: step_idx equals the lesser of the latched 7-bit code and 71.
- R7: gain_cdb is a 16-bit two's-complement value in units of 0.01 dB, equal to 2600 - ((71 - step_idx) * 7526 + 50) / 100 with integer division. This gives -2743 at index 0, 2525 at index 70 and 2600 at index 71.
- R8: rst_n low clears the shift register and latch to code 0 at once, without waiting for a clock. This gives step_idx 0, gain_cdb -2743 and load_pulse 0, and it discards a partly shifted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; serial data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| sdin | input | 1 | Serial data, most significant bit first |
| en_n | input | 1 | Active-low frame enable; its release loads the latch |
| step_idx | output | 7 | Clamped gain-step index |
| gain_cdb | output | 16 | Signed gain in 0.01 dB |
| load_pulse | output | 1 | One-cycle strobe marking a latch load |

## Verification
The properties assume that en_n is held high while rst_n is low and when it is released. Otherwise the release of a frame that was cut by reset would look like a frame end to the edge check, although the design starts with its enable history set to idle. They also assume that sdin and en_n change away from the rising edge. The bench drives both inputs only on falling clock edges and raises en_n before it asserts reset in the mid-frame case. That case checks that the half-shifted bits are lost and that no load strobe follows the reset.

// File: rtl/gain_loader_pkg.sv
package gain_loader_pkg;
  // Width of the serial shift register and of the latched code.
  localparam int unsigned CODE_W = 7;
  // Highest step index; codes above it saturate.
  localparam int unsigned IDX_TOP = 71;
  // Gain at the top step, in 0.01 dB.
  localparam int GAIN_TOP_CDB = 2600;
  // Size of one step, in 0.0001 dB.
  localparam int unsigned STEP_E4 = 7526;
  // Width of the signed gain output.
  localparam int unsigned GAIN_W = 16;
endpackage

// File: rtl/gl_shift.sv
module gl_shift #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sdin,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (shift_en) q_nxt = {q_r[W-2:0], sdin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/gl_edge_latch.sv
module gl_edge_latch #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] code,
  output logic         load
);
  logic         en_q;
  logic         rise_q;
  logic         rise_nxt;
  logic [W-1:0] code_q;
  logic [W-1:0] code_nxt;
  logic         load_q;

  // A release is an enable sampled high after one sampled low.
  always_comb begin
    rise_nxt = en_n & ~en_q;
    code_nxt = code_q;
    if (rise_q) code_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      rise_q <= 1'b0;
      code_q <= '0;
      load_q <= 1'b0;
    end else begin
      en_q   <= en_n;
      rise_q <= rise_nxt;
      code_q <= code_nxt;
      load_q <= rise_q;
    end
  end

  assign code = code_q;
  assign load = load_q;
endmodule

// File: rtl/gl_decode.sv
module gl_decode #(
  parameter int unsigned W       = 7,
  parameter int unsigned IDX_TOP = 71,
  parameter int          TOP_CDB = 2600,
  parameter int unsigned STEP_E4 = 7526,
  parameter int unsigned GW      = 16
) (
  input  logic [W-1:0]  code,
  output logic [W-1:0]  idx,
  output logic [GW-1:0] gain
);
  logic [31:0] code_ext;
  logic [31:0] idx_ext;
  logic [31:0] drop;
  logic [31:0] gain_full;

  always_comb begin
    code_ext  = 32'(code);
    idx_ext   = (code_ext > IDX_TOP) ? IDX_TOP : code_ext;
    // Distance below the top step, scaled to 0.01 dB with rounding.
    drop      = ((IDX_TOP - idx_ext) * STEP_E4 + 32'd50) / 32'd100;
    gain_full = 32'($signed(TOP_CDB) - $signed(drop));
  end

  assign idx  = idx_ext[W-1:0];
  assign gain = gain_full[GW-1:0];
endmodule

// File: rtl/gain_word_loader.sv
module gain_word_loader
  import gain_loader_pkg::*;
#(
  parameter int unsigned W       = CODE_W,
  parameter int unsigned TOP_IDX = IDX_TOP,
  parameter int          TOP_CDB = GAIN_TOP_CDB,
  parameter int unsigned STEP    = STEP_E4,
  parameter int unsigned GW      = GAIN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sdin,
  input  logic          en_n,
  output logic [W-1:0]  step_idx,
  output logic [GW-1:0] gain_cdb,
  output logic          load_pulse
);
  logic [W-1:0] shift_q;
  logic [W-1:0] held_code;
  logic         shift_en;

  assign shift_en = ~en_n;

  gl_shift #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .sdin     (sdin),
    .q        (shift_q)
  );

  gl_edge_latch #(.W(W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .en_n  (en_n),
    .d     (shift_q),
    .code  (held_code),
    .load  (load_pulse)
  );

  gl_decode #(
    .W       (W),
    .IDX_TOP (TOP_IDX),
    .TOP_CDB (TOP_CDB),
    .STEP_E4 (STEP),
    .GW      (GW)
  ) u_dec (
    .code (held_code),
    .idx  (step_idx),
    .gain (gain_cdb)
  );
endmodule

// File: rtl/gain_word_loader_chk.sv
module gain_word_loader_chk
  import gain_loader_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_n,
  input logic [CODE_W-1:0] step_idx,
  input logic [GAIN_W-1:0] gain_cdb,
  input logic              load_pulse
);
  // R3 R4: a release is followed two samples later by the load strobe
  a_r4_pulse_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_n) |-> ##2 load_pulse);

  // R4: the strobe only follows a release
  a_r4_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> ($past(en_n, 2) && !$past(en_n, 3)));

  // R4: the strobe never lasts two cycles
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);

  // R2 R3: outputs move only together with the strobe
  a_r3_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |-> $stable(step_idx));

  a_r3_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |-> $stable(gain_cdb));

  // R6: the index is clamped
  a_r6_idx_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    32'(step_idx) <= IDX_TOP);

  // R7: end points of the gain curve
  a_r7_gain_top: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(step_idx) == IDX_TOP) |-> ($signed(gain_cdb) == 16'sd2600));

  a_r7_gain_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (step_idx == '0) |-> ($signed(gain_cdb) == -16'sd2743));
endmodule

bind gain_word_loader gain_word_loader_chk u_chk (.*);

// File: tb/gain_word_loader_test.sv
`timescale 1ns/1ps
module gain_word_loader_test;
  logic        clk;
  logic        rst_n;
  logic        sdin;
  logic        en_n;
  logic [6:0]  step_idx;
  logic [15:0] gain_cdb;
  logic        load_pulse;

  int n_chk;
  int n_bad;
  bit done;
  logic [6:0] model_code;

  gain_word_loader uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdin       (sdin),
    .en_n       (en_n),
    .step_idx   (step_idx),
    .gain_cdb   (gain_cdb),
    .load_pulse (load_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam int NV = 14;
  localparam logic [7:0] VEC [NV] = '{
    8'd0, 8'd1, 8'd70, 8'd71, 8'd72, 8'd127, 8'd128, 8'd199,
    8'd200, 8'd255, 8'h55, 8'hAA, 8'd35, 8'd163
  };

  function automatic int exp_idx(input logic [6:0] c);
    return (int'(c) > 71) ? 71 : int'(c);
  endfunction

  function automatic int exp_gain(input logic [6:0] c);
    int k;
    k = 71 - exp_idx(c);
    return 2600 - (k * 7526 + 50) / 100;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input logic [6:0] c);
    check({tag, " R6 step_idx"}, int'(step_idx), exp_idx(c));
    check({tag, " R7 gain_cdb"}, int'($signed(gain_cdb)), exp_gain(c));
  endtask

  // Shift n bits of w, MSB first, then release and follow the load.
  task automatic send(input logic [15:0] w, input int n);
    logic [6:0] old_code;
    old_code = model_code;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      en_n = 1'b0;
      sdin = w[i];
      model_code = {model_code[5:0], w[i]};
    end
    @(negedge clk);
    en_n = 1'b1;
    sdin = 1'b0;
    @(negedge clk);
    check("R3 no early load_pulse", int'(load_pulse), 0);
    check_out("R3 old value held", old_code);
    @(negedge clk);
    check("R4 load_pulse on load", int'(load_pulse), 1);
    check_out("R1 loaded", model_code);
    @(negedge clk);
    check("R4 load_pulse one cycle", int'(load_pulse), 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    done = 1'b0;
    model_code = 7'd0;
    rst_n = 1'b0;
    en_n = 1'b1;
    sdin = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset load_pulse", int'(load_pulse), 0);
    check_out("R8 reset", 7'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: full 8-bit words.
    for (int v = 0; v < NV; v++) begin
      send(16'(VEC[v]), 8);
      check("R1 code is word[6:0]", int'(step_idx), exp_idx(VEC[v][6:0]));
    end

    // R5: word and word+128 agree.
    send(16'd45, 8);
    begin
      int g0;
      int i0;
      g0 = int'($signed(gain_cdb));
      i0 = int'(step_idx);
      send(16'd173, 8);
      check("R5 mirror gain", int'($signed(gain_cdb)), g0);
      check("R5 mirror idx", int'(step_idx), i0);
    end

    // R2: clocks with enable high and sdin toggling change nothing.
    send(16'h2C, 8);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      sdin = i[0];
      check("R2 load_pulse idle", int'(load_pulse), 0);
      check_out("R2 idle hold", model_code);
    end
    // One more bit reveals the shift register kept its contents.
    send(16'd1, 1);

    // R1: a long frame keeps only the last 7 bits.
    send(16'b1011_0011_0101, 12);
    // R1: a short frame shifts the old contents up.
    send(16'b011, 3);

    // R8: reset in mid-frame discards the partial bits.
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      en_n = 1'b0;
      sdin = 1'b1;
    end
    @(negedge clk);
    en_n = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    check("R8 async clear idx", int'(step_idx), 0);
    check("R8 async clear gain", int'($signed(gain_cdb)), -2743);
    check("R8 async clear pulse", int'(load_pulse), 0);
    model_code = 7'd0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 no pulse after reset", int'(load_pulse), 0);
      check_out("R8 cleared", 7'd0);
    end
    send(16'd1, 1);
    send(16'd127, 8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule